// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-port synchronous static memory. Its 18-bit word is split into two 9-bit lanes, and each lane holds eight data bits plus one parity bit. Reads and writes can follow each other on consecutive clock edges with no idle turnaround. An address and command are registered on a rising edge. Read data then comes straight out of the array, with no further register, and is valid in the cycle that follows that edge. A write supplies its data and lane strobes one edge after its command. That one-edge delay is what lets a read issued on the next edge still find the data bus free.

A registered two-bit beat counter steps through a four-word burst. The beat counter is combined with the two low bits of the loaded address in either linear order (sum modulo four) or interleaved order (bitwise XOR), chosen by a static select input. An active-low clock enable freezes the whole pipeline, which stretches the current cycle. Three chip-select inputs with mixed polarity gate each newly loaded command. The data pins are modelled as separate input and output buses plus a drive-enable flag. That flag combines the block's internal state with an asynchronous active-low output enable.

Top module: `sram_ft_burst`

## Requirements
- R1: While `clk_en_n` is high, rising edges have no effect. The registered command, the burst position and the memory contents all stay unchanged, so `dout` and `dout_en` keep their values.
- R2: A load (`burst_adv` low with `clk_en_n` low) selects the block only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination loads a deselected state.
- R3: An advance (`burst_adv` high) on a selected block keeps the operation type and steps the beat counter k = 0,1,2,3 (wrapping after 3). With `order_ilv`=0 the word address is {base[high bits], (base[1:0]+k) mod 4}.
- R4: With `order_ilv`=1 the low two address bits are base[1:0] XOR k, and the upper bits stay at the base value.
- R5: An advance while deselected leaves the block deselected, so `dout_en`=0 and `dout`=0.
- R6: A write is loaded with `wr_n`=0. Its data is taken from `din` on the next enabled edge. `lane_wr_n[0]` (active low) enables `din[8:0]` and `lane_wr_n[1]` enables `din[17:9]`. A disabled lane keeps its old 9 bits.
- R7: After the edge that loads or advances a read, `dout` shows the addressed word in that same cycle, with no further edge needed.
- R8: `dout_en` is 0 whenever the registered command is a write data phase or the block is deselected, whatever the value of `drv_en_n`.
- R9: During a read, `dout_en` equals the inverse of `drv_en_n`, and follows it without waiting for a clock edge.
- R10: A read loaded on the edge right after a write command returns the word that write stores, with no idle cycle in between.
- R11: After synchronous reset the block is deselected, `dout_en`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address for a load |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 loads a write, 1 loads a read |
| lane_wr_n | input | LANES | Per-lane write strobes, active low, taken with the data |
| burst_adv | input | 1 | 1 advances the burst, 0 loads a new command |
| clk_en_n | input | 1 | Clock enable, active low |
| drv_en_n | input | 1 | Asynchronous output enable, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | DATA_W | Write data, taken one edge after its command |
| dout | output | DATA_W | Read data, zero when no read is in progress |
| dout_en | output | 1 | Data bus drive enable |

## Verification
On every cycle the assertions check the following: the freeze under a deasserted clock enable, the chip-select decode on loads, that an advance continues the operation type and steps the beat, that an advance cannot wake a deselected block, that masked lanes keep their contents, and the output-drive rules. The actual burst address sequences in both orders, the data values read after writes with different lane masks, read-after-write with no gap, and the asynchronous response of the drive enable can only be shown by the bench's scenarios. Those scenarios compare the design against a bench-side copy of the memory.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    typedef struct packed {
        logic              act;
        op_e               op;
        logic [BEAT_W-1:0] beat;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{act: 1'b0, op: OP_RD, beat: '0};

    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              ilv
    );
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl
    import sram_ft_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              burst_adv,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              cmd_act,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    cmd_t              st_q, st_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic              chip_sel;

    assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        if (!clk_en_n) begin
            if (!burst_adv) begin
                st_d.act  = chip_sel;
                st_d.op   = wr_n ? OP_RD : OP_WR;
                st_d.beat = '0;
                base_d    = ld_addr;
            end else if (st_q.act) begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CMD_IDLE;
            base_q <= '0;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
        end
    end

    assign cmd_act  = st_q.act;
    assign cmd_wr   = (st_q.op == OP_WR);
    assign cur_addr = {base_q[ADDR_W-1 -: HI_W],
                       beat_offset(base_q[BEAT_W-1:0], st_q.beat, order_ilv)};

    a_r1_freeze: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(st_q) && $stable(base_q)));

    a_r2_decode: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_adv) |=> (st_q.act == $past(!sel_a_n && sel_b && !sel_c_n)));

    a_r3_keep_op: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && burst_adv && st_q.act) |=>
            (st_q.act && st_q.op == $past(st_q.op) && st_q.beat == $past(st_q.beat) + 2'd1));

    a_r5_stay_off: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && burst_adv && !st_q.act) |=> !st_q.act);

endmodule

// File: rtl/sram_ft_lane.sv
module sram_ft_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              lane_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic              wr_fire;

    assign wr_fire = wr_cmd && lane_en && !rst;

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    a_r6_lane_keep: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && !lane_en) |=> (mem[$past(addr)] === $past(mem[addr])));

endmodule

// File: rtl/sram_ft_drive.sv
module sram_ft_drive #(
    parameter int DATA_W = 18
) (
    input  logic              cmd_act,
    input  logic              cmd_wr,
    input  logic              drv_en_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic rd_phase;

    assign rd_phase = cmd_act && !cmd_wr;
    assign dout     = rd_phase ? rd_word : '0;
    assign dout_en  = rd_phase && !drv_en_n;

endmodule

// File: rtl/sram_ft_burst.sv
module sram_ft_burst
    import sram_ft_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              burst_adv,
    input  logic              clk_en_n,
    input  logic              drv_en_n,
    input  logic              order_ilv,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              cmd_act;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cur_addr;
    logic              wr_cmd;
    logic [DATA_W-1:0] rd_word;

    sram_ft_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .clk_en_n  (clk_en_n),
        .burst_adv (burst_adv),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .wr_n      (wr_n),
        .order_ilv (order_ilv),
        .ld_addr   (addr),
        .cmd_act   (cmd_act),
        .cmd_wr    (cmd_wr),
        .cur_addr  (cur_addr)
    );

    // data phase of a registered write, qualified by the clock enable
    assign wr_cmd = cmd_act && cmd_wr && !clk_en_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_ft_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) lane_i (
            .clk     (clk),
            .rst     (rst),
            .wr_cmd  (wr_cmd),
            .lane_en (!lane_wr_n[g]),
            .addr    (cur_addr),
            .wdata   (din[g*LANE_W +: LANE_W]),
            .rdata   (rd_word[g*LANE_W +: LANE_W])
        );
    end

    sram_ft_drive #(.DATA_W(DATA_W)) drive_i (
        .cmd_act  (cmd_act),
        .cmd_wr   (cmd_wr),
        .drv_en_n (drv_en_n),
        .rd_word  (rd_word),
        .dout     (dout),
        .dout_en  (dout_en)
    );

    a_r8_off_in_write: assert property (@(posedge clk) disable iff (rst)
        (cmd_act && cmd_wr) |-> !dout_en);

    a_r8_off_desel: assert property (@(posedge clk) disable iff (rst)
        !cmd_act |-> !dout_en);

    a_r9_oe_follows: assert property (@(posedge clk) disable iff (rst)
        (cmd_act && !cmd_wr) |-> (dout_en == !drv_en_n));

endmodule

// File: tb/sram_ft_burst_tb_top.sv
module sram_ft_burst_tb_top;

    localparam int AW = 6;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] CS_ON  = 3'b010;  // {sel_c_n, sel_b, sel_a_n}
    localparam logic [2:0] CS_OFF = 3'b000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic          burst_adv = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          drv_en_n = 1'b0;
    logic          order_ilv = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    sram_ft_burst dut_i (
        .clk(clk), .rst(rst), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .burst_adv(burst_adv),
        .clk_en_n(clk_en_n), .drv_en_n(drv_en_n), .order_ilv(order_ilv),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 1031 + 677) & 32'h3FFFF);
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k, input logic ilv);
        logic [1:0] lo;
        lo = ilv ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [1:0] bw);
        logic [DW-1:0] r;
        r = old;
        if (!bw[0]) r[8:0]  = nw[8:0];
        if (!bw[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // drive one cycle: inputs set at negedge, sampled 2 ns after the posedge
    task automatic cyc(input logic hold, input logic adv, input logic [2:0] cs, input logic wr,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] bw);
        @(negedge clk);
        clk_en_n  = hold;
        burst_adv = adv;
        {sel_c_n, sel_b, sel_a_n} = cs;
        wr_n      = !wr;
        addr      = a;
        din       = d;
        lane_wr_n = bw;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] ea;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #2;
        // R11: reset state
        chk("R11 dout_en after reset", 32'(dout_en), 0);
        chk("R11 dout after reset", 32'(dout), 0);

        // fill every word, back-to-back writes; data follows one edge later (R6)
        for (int a = 0; a < DEPTH; a++) begin
            cyc(0, 0, CS_ON, 1, AW'(a), (a > 0) ? pat(a - 1) : '0, 2'b00);
            chk("R8 dout_en in write data phase", 32'(dout_en), 0);
            ref_mem[a] = pat(a);
        end
        // read sweep; first read carries last write data (R10, R7)
        for (int a = 0; a < DEPTH; a++) begin
            cyc(0, 0, CS_ON, 0, AW'(a), pat(DEPTH - 1), 2'b00);
            chk("R7 flow-through read data", 32'(dout), 32'(ref_mem[a]));
            chk("R9 dout_en with drv_en_n low", 32'(dout_en), 1);
        end

        // read bursts, both orders, every start offset (R3, R4)
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int b = 16; b < 20; b++) begin
                order_ilv = 1'(ilv);
                for (int k = 0; k < 4; k++) begin
                    cyc(0, (k > 0), CS_ON, 0, AW'(b), '0, 2'b11);
                    ea = beat_addr(AW'(b), k, 1'(ilv));
                    if (ilv == 0) chk("R3 linear burst read", 32'(dout), 32'(ref_mem[ea]));
                    else          chk("R4 interleaved burst read", 32'(dout), 32'(ref_mem[ea]));
                end
                // fifth beat wraps to the start word
                cyc(0, 1, CS_ON, 0, '0, '0, 2'b11);
                chk("R3 burst wrap", 32'(dout), 32'(ref_mem[b]));
            end
        end

        // interleaved write burst from base 45 (R3 op continues, R4)
        order_ilv = 1'b1;
        cyc(0, 0, CS_ON, 1, AW'(45), '0, 2'b00);
        for (int k = 1; k < 5; k++) begin
            cyc(0, (k < 4), (k < 4) ? CS_ON : CS_OFF, 0, '0, DW'(18'h15000 + k - 1), 2'b00);
            ref_mem[beat_addr(AW'(45), k - 1, 1'b1)] = DW'(18'h15000 + k - 1);
            if (k < 4) chk("R3 write burst keeps op, output off", 32'(dout_en), 0);
        end
        order_ilv = 1'b0;
        for (int a = 44; a < 48; a++) begin
            cyc(0, 0, CS_ON, 0, AW'(a), '0, 2'b11);
            chk("R4 write burst readback", 32'(dout), 32'(ref_mem[a]));
        end

        // lane masking at word 7 (R6)
        for (int m = 0; m < 3; m++) begin
            logic [1:0] bw;
            logic [DW-1:0] d;
            bw = (m == 0) ? 2'b10 : (m == 1) ? 2'b01 : 2'b11;
            d  = (m == 0) ? 18'h3FFFF : (m == 1) ? 18'h00000 : 18'h2AAAA;
            cyc(0, 0, CS_ON, 1, AW'(7), '0, 2'b11);
            cyc(0, 0, CS_OFF, 0, '0, d, bw);
            ref_mem[7] = merge(ref_mem[7], d, bw);
            chk("R8 output off while deselected", 32'(dout_en), 0);
            cyc(0, 0, CS_ON, 0, AW'(7), '0, 2'b11);
            chk("R6 lane masked write", 32'(dout), 32'(ref_mem[7]));
        end

        // alternating write / read every cycle (R10)
        for (int i = 0; i < 8; i++) begin
            logic [DW-1:0] nv;
            nv = DW'(18'h0A000 + i * 291);
            cyc(0, 0, CS_ON, 1, AW'(50 + i), '0, 2'b00);
            chk("R8 write data phase output off", 32'(dout_en), 0);
            cyc(0, 0, CS_ON, 0, AW'(50 + i), nv, 2'b00);
            ref_mem[50 + i] = nv;
            chk("R10 read right after write", 32'(dout), 32'(nv));
        end

        // clock enable hold (R1): read held while other inputs change
        cyc(0, 0, CS_ON, 0, AW'(9), '0, 2'b11);
        cyc(1, 0, CS_ON, 1, AW'(12), 18'h3FFFF, 2'b00);
        chk("R1 read held under clock enable", 32'(dout), 32'(ref_mem[9]));
        chk("R1 drive held under clock enable", 32'(dout_en), 1);
        // write data taken only on an enabled edge
        cyc(0, 0, CS_ON, 1, AW'(12), '0, 2'b00);
        cyc(1, 0, CS_ON, 0, AW'(13), 18'h11111, 2'b00);
        cyc(0, 0, CS_ON, 0, AW'(12), 18'h22222, 2'b00);
        ref_mem[12] = 18'h22222;
        chk("R1 write data from enabled edge", 32'(dout), 32'(ref_mem[12]));
        cyc(0, 0, CS_ON, 0, AW'(13), '0, 2'b11);
        chk("R1 held edge wrote nothing", 32'(dout), 32'(ref_mem[13]));

        // chip-select decode, all eight combinations (R2)
        for (int c = 0; c < 8; c++) begin
            cyc(0, 0, 3'(c), 0, AW'(5), '0, 2'b11);
            chk("R2 select decode dout_en", 32'(dout_en), (c == 2) ? 1 : 0);
            chk("R2 select decode dout", 32'(dout), (c == 2) ? 32'(ref_mem[5]) : 0);
        end
        // advance after deselect stays off (R5)
        cyc(0, 1, CS_ON, 0, AW'(5), '0, 2'b11);
        chk("R5 advance while deselected", 32'(dout_en), 0);
        chk("R5 advance while deselected dout", 32'(dout), 0);

        // asynchronous output enable (R9)
        cyc(0, 0, CS_ON, 0, AW'(20), '0, 2'b11);
        drv_en_n = 1'b1; #1;
        chk("R9 drv_en_n high turns drive off", 32'(dout_en), 0);
        drv_en_n = 1'b0; #1;
        chk("R9 drv_en_n low turns drive on", 32'(dout_en), 1);
        // R8: drive stays off in a write data phase even with drv_en_n low
        cyc(0, 0, CS_ON, 1, AW'(21), '0, 2'b00);
        chk("R8 write phase ignores drv_en_n", 32'(dout_en), 0);
        cyc(0, 0, CS_OFF, 0, '0, ref_mem[21], 2'b00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule